// File: doc/BRIEF.md
# Descriptor-Driven Bus Master DMA Engine

This block moves sector data between a drive-side byte stream and system memory. It does not need a host processor to copy each byte. Software builds a table of region descriptors in memory and writes the table's start address into the block. It then sets the start bit together with a transfer direction. The engine reads the descriptors one at a time and moves the bytes of each region. It stops when the final region is used up, when the drive marks its final byte, or when software clears the start bit.

The way a run ends is encoded precisely in the status register:
- The table and the drive can run out at the same byte.
- The table can end before the drive has finished.
- The drive can finish while table space remains.

Each of these leaves a different ACTIVE/interrupt combination, so software can tell them apart. The interrupt line follows the interrupt status bit.

The memory port is a single-outstanding request/grant port with 32-bit words and byte strobes. A read returns `mem_rvalid` with `mem_rdata` some cycles after the cycle in which the request was granted.

The drive side consists of two byte streams, one per direction.
- A byte moves only in a cycle where valid and ready are both high.
- The drive may hold valid low for as long as it likes.
- Once the engine raises `dev_out_valid`, it keeps the byte stable until it is taken or the run is stopped.
- `drv_final` is sampled only on a handshake in either direction. When set, it marks that byte as the drive's last byte for the command.

Top module: `bmdma_engine`

## Requirements
- R1: After reset the status reads 0, `irq_o` is low, the table base reads 0, and the block makes no memory request and moves no stream byte.
- R2: Each table entry is 8 bytes at the table pointer. The first little-endian 32-bit word is the region address. The second is the size word, whose bit 31 marks the final entry. Bit 0 of both the address and the size is ignored. The low SIZE_W bits give the byte count, and a count of zero means 2^SIZE_W bytes. Region bytes go to ascending addresses on byte lane addr[1:0], with exactly one strobe set per write.
- R3: Register offset 0 is the command register: bit 0 is start and bit 3 is direction (1 = drive to memory, 0 = memory to drive). Writing start=1 while inactive sets ACTIVE and starts the walk at the table base. The walk restarts from the base on every start.
- R4: When the drive's final byte is also the last byte of the final entry, the run ends with ACTIVE=0 and interrupt=1 (status 0x04).
- R5: When the final entry is used up before the drive's final byte, the run ends with ACTIVE=0 and interrupt=0. No further bytes move.
- R6: When the drive's final byte arrives with table space left over, the status reads ACTIVE=1 and interrupt=1 (0x05), and no further bytes move.
- R7: Writing the command register with bit 0 clear stops the engine. ACTIVE clears and the interrupt bit keeps its value.
- R8: Register offset 1 is the status register: bit 0 is ACTIVE (read-only) and bit 2 is interrupt. Writing 1 to bit 2 clears the interrupt. `irq_o` equals the interrupt bit.
- R9: Register offset 2 is the table base. Its low two bits always read 0. Writes to it while ACTIVE is set are ignored.
- R10: A stream byte moves only on valid and ready together. A presented output byte stays stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data of the selected register |
| irq_o | output | 1 | Interrupt line |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write data (byte replicated on all lanes) |
| mem_wstrb | output | 4 | Byte strobes for writes |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| dev_in_valid | input | 1 | Drive offers a byte for memory |
| dev_in_data | input | 8 | Byte from the drive |
| dev_in_ready | output | 1 | Engine accepts a drive byte |
| dev_out_valid | output | 1 | Engine offers a byte to the drive |
| dev_out_data | output | 8 | Byte to the drive |
| dev_out_ready | input | 1 | Drive accepts the byte |
| drv_final | input | 1 | Handshaked byte is the drive's last |

## Verification
The bench builds the engine with SIZE_W=8. This brings the zero-size case within a short run: a size field of zero then covers a full 256-byte region rather than 65536 bytes. The memory model grants only every other cycle, so every request has to hold under back-pressure. The descriptor set mixes a two-entry table with odd address and size values, as well as short, exact and oversized tables in both directions. It also covers a stop in the middle of a region and a restart without rewriting the base.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int REG_CMD       = 0;
  localparam int REG_STAT      = 1;
  localparam int REG_BASE      = 2;
  localparam int CMD_START_BIT = 0;
  localparam int CMD_DIR_BIT   = 3;
  localparam int STAT_ACT_BIT  = 0;
  localparam int STAT_INT_BIT  = 2;
  localparam int DESC_LAST_BIT = 31;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DESC_REQ,
    ST_DESC_WAIT,
    ST_IN_BYTE,
    ST_MEM_WR,
    ST_MEM_RD,
    ST_RD_WAIT,
    ST_OUT_BYTE,
    ST_HOLD
  } eng_state_t;
endpackage

// File: rtl/bmdma_regs.sv
module bmdma_regs import bmdma_pkg::*; #(
  parameter int AW   = 32,
  parameter int RA_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  input  logic            active_i,
  input  logic            set_intr_i,
  output logic [31:0]     reg_rdata,
  output logic            start_o,
  output logic            stop_o,
  output logic            dir_o,
  output logic [AW-1:0]   base_o,
  output logic            intr_o
);
  logic          cmd_start_q, cmd_dir_q, run_dir_q, intr_q;
  logic [AW-1:0] base_q;
  logic          wr_cmd, wr_stat, wr_base;
  logic          unused_wbits;

  assign wr_cmd  = reg_wr && (reg_addr == RA_W'(REG_CMD));
  assign wr_stat = reg_wr && (reg_addr == RA_W'(REG_STAT));
  assign wr_base = reg_wr && (reg_addr == RA_W'(REG_BASE));
  assign start_o = wr_cmd && reg_wdata[CMD_START_BIT] && !active_i;
  assign stop_o  = wr_cmd && !reg_wdata[CMD_START_BIT];
  assign unused_wbits = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_start_q <= 1'b0;
      cmd_dir_q   <= 1'b0;
      run_dir_q   <= 1'b0;
      intr_q      <= 1'b0;
      base_q      <= '0;
    end else begin
      if (wr_cmd) begin
        cmd_start_q <= reg_wdata[CMD_START_BIT];
        cmd_dir_q   <= reg_wdata[CMD_DIR_BIT];
      end
      if (start_o) run_dir_q <= reg_wdata[CMD_DIR_BIT];
      if (set_intr_i) intr_q <= 1'b1;
      else if (wr_stat && reg_wdata[STAT_INT_BIT]) intr_q <= 1'b0;
      if (wr_base && !active_i) base_q <= {reg_wdata[AW-1:2], 2'b00};
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_W'(REG_CMD): begin
        reg_rdata[CMD_START_BIT] = cmd_start_q;
        reg_rdata[CMD_DIR_BIT]   = cmd_dir_q;
      end
      RA_W'(REG_STAT): begin
        reg_rdata[STAT_ACT_BIT] = active_i;
        reg_rdata[STAT_INT_BIT] = intr_q;
      end
      RA_W'(REG_BASE): reg_rdata[AW-1:0] = base_q;
      default: reg_rdata = '0;
    endcase
  end

  assign dir_o  = run_dir_q;
  assign base_o = base_q;
  assign intr_o = intr_q;
endmodule

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl import bmdma_pkg::*; #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int SIZE_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            dir_i,
  input  logic [AW-1:0]   base_i,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW/8-1:0] mem_wstrb,
  input  logic            mem_gnt,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            dev_in_valid,
  input  logic [7:0]      dev_in_data,
  output logic            dev_in_ready,
  output logic            dev_out_valid,
  output logic [7:0]      dev_out_data,
  input  logic            dev_out_ready,
  input  logic            drv_final,
  output logic            active_o,
  output logic            set_intr_o
);
  localparam int LANES  = DW / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int CNT_W  = SIZE_W + 1;
  localparam logic [CNT_W-1:0] FULL_REGION = CNT_W'(1) << SIZE_W;

  eng_state_t       st_q, nxt_step;
  logic [AW-1:0]    ptr_q, cur_q;
  logic [CNT_W-1:0] left_q;
  logic             last_q, half_q, rd_pend_q, fin_q, active_q;
  logic [7:0]       byte_q, rd_byte;
  logic [SIZE_W-1:0] sz_field;
  logic             step, step_fin, region_end, tbl_end, rd_issue;
  logic             unused_rbits;

  assign unused_rbits = ^mem_rdata;
  assign sz_field   = mem_rdata[SIZE_W-1:0] & ~SIZE_W'(1);
  assign rd_byte    = mem_rdata[{cur_q[LANE_W-1:0], 3'b000} +: 8];
  assign region_end = (left_q == CNT_W'(1));
  assign tbl_end    = region_end && last_q;
  assign step       = ((st_q == ST_MEM_WR) && mem_gnt) ||
                      ((st_q == ST_OUT_BYTE) && dev_out_ready);
  assign step_fin   = (st_q == ST_MEM_WR) ? fin_q : drv_final;
  assign set_intr_o = step && step_fin && !stop_i;
  assign rd_issue   = mem_req && mem_gnt && !mem_we;

  always_comb begin
    nxt_step = dir_i ? ST_IN_BYTE : ST_MEM_RD;
    if (tbl_end)         nxt_step = ST_IDLE;
    else if (step_fin)   nxt_step = ST_HOLD;
    else if (region_end) nxt_step = ST_DESC_REQ;
  end

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = {cur_q[AW-1:LANE_W], {LANE_W{1'b0}}};
    case (st_q)
      ST_DESC_REQ: begin mem_req = !rd_pend_q; mem_addr = ptr_q; end
      ST_MEM_RD:   mem_req = !rd_pend_q;
      ST_MEM_WR:   begin mem_req = 1'b1; mem_we = 1'b1; end
      default: ;
    endcase
  end

  assign mem_wdata     = {LANES{byte_q}};
  assign mem_wstrb     = {{(LANES-1){1'b0}}, 1'b1} << cur_q[LANE_W-1:0];
  assign dev_in_ready  = (st_q == ST_IN_BYTE);
  assign dev_out_valid = (st_q == ST_OUT_BYTE);
  assign dev_out_data  = byte_q;
  assign active_o      = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ptr_q     <= '0;
      cur_q     <= '0;
      left_q    <= '0;
      last_q    <= 1'b0;
      half_q    <= 1'b0;
      rd_pend_q <= 1'b0;
      fin_q     <= 1'b0;
      active_q  <= 1'b0;
      byte_q    <= '0;
    end else begin
      if (rd_issue)        rd_pend_q <= 1'b1;
      else if (mem_rvalid) rd_pend_q <= 1'b0;
      if (stop_i) begin
        st_q     <= ST_IDLE;
        active_q <= 1'b0;
      end else begin
        case (st_q)
          ST_IDLE: if (start_i) begin
            st_q     <= ST_DESC_REQ;
            ptr_q    <= base_i;
            half_q   <= 1'b0;
            active_q <= 1'b1;
          end
          ST_DESC_REQ: if (mem_req && mem_gnt) begin
            ptr_q <= ptr_q + AW'(LANES);
            st_q  <= ST_DESC_WAIT;
          end
          ST_DESC_WAIT: if (mem_rvalid) begin
            if (!half_q) begin
              cur_q  <= mem_rdata[AW-1:0] & ~AW'(1);
              half_q <= 1'b1;
              st_q   <= ST_DESC_REQ;
            end else begin
              half_q <= 1'b0;
              last_q <= mem_rdata[DESC_LAST_BIT];
              left_q <= (sz_field == '0) ? FULL_REGION : {1'b0, sz_field};
              st_q   <= dir_i ? ST_IN_BYTE : ST_MEM_RD;
            end
          end
          ST_IN_BYTE: if (dev_in_valid) begin
            byte_q <= dev_in_data;
            fin_q  <= drv_final;
            st_q   <= ST_MEM_WR;
          end
          ST_MEM_RD: if (mem_req && mem_gnt) st_q <= ST_RD_WAIT;
          ST_RD_WAIT: if (mem_rvalid) begin
            byte_q <= rd_byte;
            st_q   <= ST_OUT_BYTE;
          end
          ST_MEM_WR, ST_OUT_BYTE: if (step) begin
            cur_q  <= cur_q + AW'(1);
            left_q <= left_q - CNT_W'(1);
            st_q   <= nxt_step;
            if (tbl_end) active_q <= 1'b0;
          end
          ST_HOLD: ;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine import bmdma_pkg::*; #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int SIZE_W = 16,
  parameter int RA_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            irq_o,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW/8-1:0] mem_wstrb,
  input  logic            mem_gnt,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            dev_in_valid,
  input  logic [7:0]      dev_in_data,
  output logic            dev_in_ready,
  output logic            dev_out_valid,
  output logic [7:0]      dev_out_data,
  input  logic            dev_out_ready,
  input  logic            drv_final
);
  logic          start, stop, dir, active, set_intr, intr;
  logic [AW-1:0] base;

  bmdma_regs #(.AW(AW), .RA_W(RA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .active_i(active), .set_intr_i(set_intr),
    .reg_rdata(reg_rdata), .start_o(start), .stop_o(stop), .dir_o(dir),
    .base_o(base), .intr_o(intr)
  );

  bmdma_ctrl #(.AW(AW), .DW(DW), .SIZE_W(SIZE_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop), .dir_i(dir),
    .base_i(base), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
    .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
    .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
    .drv_final(drv_final), .active_o(active), .set_intr_o(set_intr)
  );

  assign irq_o = intr;
endmodule

// File: rtl/bmdma_checker.sv
module bmdma_checker #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int RA_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [RA_W-1:0] reg_addr,
  input logic [31:0]     reg_wdata,
  input logic            irq_o,
  input logic            mem_req,
  input logic            mem_we,
  input logic [DW/8-1:0] mem_wstrb,
  input logic            dev_in_ready,
  input logic            dev_out_valid,
  input logic [7:0]      dev_out_data,
  input logic            dev_out_ready,
  input logic            active,
  input logic            set_intr,
  input logic [AW-1:0]   base
);
  logic wr_cmd, wr_stat, wr_base;
  assign wr_cmd  = reg_wr && (reg_addr == RA_W'(0));
  assign wr_stat = reg_wr && (reg_addr == RA_W'(1));
  assign wr_base = reg_wr && (reg_addr == RA_W'(2));

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ($countones(mem_wstrb) == 1)); // R2
  AST_START_SETS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && reg_wdata[0] && !active) |=> active); // R3
  AST_STOP_CLEARS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !reg_wdata[0]) |=> !active); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!mem_req && !dev_in_ready && !dev_out_valid)); // R7
  AST_INTR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[2] && !set_intr) |=> !irq_o); // R8
  AST_BASE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base && active) |=> $stable(base)); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_out_valid && !dev_out_ready && !(wr_cmd && !reg_wdata[0]))
      |=> (dev_out_valid && $stable(dev_out_data))); // R10
endmodule

bind bmdma_engine bmdma_checker #(.AW(AW), .DW(DW), .RA_W(RA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq_o(irq_o), .mem_req(mem_req), .mem_we(mem_we),
  .mem_wstrb(mem_wstrb), .dev_in_ready(dev_in_ready),
  .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
  .dev_out_ready(dev_out_ready), .active(active), .set_intr(set_intr),
  .base(base)
);

// File: tb/bmdma_engine_tb_top.sv
module bmdma_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq_o, mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0] mem_wstrb;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic dev_in_valid = 1'b0, dev_in_ready, dev_out_valid, dev_out_ready = 1'b0;
  logic drv_final = 1'b0;
  logic [7:0] dev_in_data = '0, dev_out_data;
  logic gnt_en = 1'b0;
  logic [7:0] mem_b [0:1023];
  logic [7:0] rx [0:255];
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmdma_engine #(.SIZE_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
    .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
    .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
    .drv_final(drv_final)
  );

  assign mem_gnt = mem_req && gnt_en;

  always @(posedge clk) begin
    gnt_en <= ~gnt_en;
    mem_rvalid <= 1'b0;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_wstrb[k]) mem_b[{mem_addr[9:2], 2'(k)}] = mem_wdata[8*k +: 8];
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= {mem_b[{mem_addr[9:2], 2'd3}], mem_b[{mem_addr[9:2], 2'd2}],
                       mem_b[{mem_addr[9:2], 2'd1}], mem_b[{mem_addr[9:2], 2'd0}]};
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input int a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input int a, output logic [31:0] d);
    reg_addr = 2'(a);
    #1 d = reg_rdata;
  endtask

  task automatic put_desc(input int at, input logic [31:0] a, input logic [31:0] s);
    for (int k = 0; k < 4; k++) begin
      mem_b[at + k]     = a[8*k +: 8];
      mem_b[at + 4 + k] = s[8*k +: 8];
    end
  endtask

  task automatic fill_data();
    for (int i = 256; i < 1024; i++) mem_b[i] = 8'hEE;
  endtask

  task automatic src_run(input int n, input logic [7:0] seed, input bit mark_final,
                         output int sent);
    int idle = 0;
    sent = 0;
    while (sent < n && idle < 40) begin
      dev_in_valid = 1'b1;
      dev_in_data  = seed + 8'(sent * 3);
      drv_final    = mark_final && (sent == n - 1);
      if (dev_in_ready) begin sent++; idle = 0; end else idle++;
      @(negedge clk);
    end
    dev_in_valid = 1'b0; drv_final = 1'b0;
  endtask

  task automatic snk_run(input int n, output int got);
    int idle = 0;
    got = 0;
    while (got < n && idle < 40) begin
      dev_out_ready = 1'b1;
      drv_final = (got == n - 1);
      if (dev_out_valid) begin rx[got] = dev_out_data; got++; idle = 0; end
      else idle++;
      @(negedge clk);
    end
    dev_out_ready = 1'b0; drv_final = 1'b0;
  endtask

  task automatic settle(); repeat (12) @(negedge clk); endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_read(1, v); chk(v == 0, "R1 status", v, 0);
    reg_read(2, v); chk(v == 0, "R1 base", v, 0);
    chk(!irq_o && !mem_req && !dev_in_ready && !dev_out_valid, "R1 idle pins",
        {irq_o, mem_req, dev_in_ready, dev_out_valid}, 0);
  endtask

  task automatic t_exact_to_mem();
    logic [31:0] v; int sent; bit ok = 1;
    fill_data();
    put_desc(0, 32'h100, 32'h6);
    put_desc(8, 32'h181, 32'h8000_000B);
    reg_write(2, 32'h0);
    reg_write(0, 32'h9);
    src_run(16, 8'h10, 1, sent);
    settle();
    chk(sent == 16, "R4 bytes taken", sent, 16);
    for (int i = 0; i < 6; i++) if (mem_b[256 + i] !== 8'(8'h10 + i * 3)) ok = 0;
    for (int j = 0; j < 10; j++) if (mem_b[384 + j] !== 8'(8'h10 + (6 + j) * 3)) ok = 0;
    chk(ok, "R2 region bytes, odd addr/size", ok, 1);
    chk(mem_b[262] == 8'hEE && mem_b[394] == 8'hEE, "R2 region bounds",
        {mem_b[262], mem_b[394]}, 16'hEEEE);
    reg_read(1, v); chk(v == 32'h4, "R4 exact status", v, 4);
    chk(irq_o == 1'b1, "R8 irq follows", irq_o, 1);
    reg_write(1, 32'h1);
    reg_read(1, v); chk(v == 32'h4, "R8 active bit read-only", v, 4);
    reg_write(1, 32'h4);
    reg_read(1, v); chk(v == 32'h0, "R8 write-one clear", v, 0);
    chk(irq_o == 1'b0, "R8 irq low after clear", irq_o, 0);
  endtask

  task automatic t_short_to_dev();
    logic [31:0] v; int got; bit ok = 1;
    fill_data();
    for (int i = 0; i < 8; i++) mem_b[512 + i] = 8'hA0 + 8'(i);
    put_desc(32, 32'h200, 32'h8000_0008);
    reg_write(2, 32'h20);
    reg_write(0, 32'h1);
    snk_run(20, got);
    chk(got == 8, "R5 only table bytes move", got, 8);
    for (int i = 0; i < 8; i++) if (rx[i] !== 8'hA0 + 8'(i)) ok = 0;
    chk(ok, "R2 bytes to drive in order", ok, 1);
    reg_read(1, v); chk(v == 32'h0, "R5 short status", v, 0);
  endtask

  task automatic t_long_to_mem();
    logic [31:0] v; int sent;
    fill_data();
    put_desc(64, 32'h300, 32'h8000_0020);
    reg_write(2, 32'h40);
    reg_write(0, 32'h9);
    src_run(12, 8'h50, 1, sent);
    settle();
    chk(sent == 12, "R6 bytes taken", sent, 12);
    reg_read(1, v); chk(v == 32'h5, "R6 long status", v, 5);
    chk(mem_b[780] == 8'hEE && mem_b[779] == 8'(8'h50 + 33), "R6 no byte past final",
        {mem_b[779], mem_b[780]}, {8'(8'h50 + 33), 8'hEE});
    reg_write(2, 32'hF0);
    reg_read(2, v); chk(v == 32'h40, "R9 base locked while active", v, 32'h40);
    reg_write(0, 32'h0);
    reg_read(1, v); chk(v == 32'h4, "R7 stop keeps intr", v, 4);
    reg_write(1, 32'h4);
  endtask

  task automatic t_abort_mid();
    logic [31:0] v; int sent;
    fill_data();
    reg_write(0, 32'h9);
    src_run(3, 8'h70, 0, sent);
    settle();
    reg_read(1, v); chk(v == 32'h1, "R3 running before stop", v, 1);
    reg_write(0, 32'h8);
    reg_read(1, v); chk(v == 32'h0, "R7 stop mid-run", v, 0);
    chk(mem_b[770] == 8'(8'h70 + 6) && mem_b[771] == 8'hEE, "R7 bytes up to stop",
        {mem_b[770], mem_b[771]}, {8'(8'h70 + 6), 8'hEE});
    chk(!dev_in_ready, "R10 no ready after stop", dev_in_ready, 0);
  endtask

  task automatic t_reload();
    logic [31:0] v; int got;
    fill_data();
    for (int i = 0; i < 8; i++) mem_b[256 + i] = 8'hC0 + 8'(i);
    put_desc(96, 32'h100, 32'h8000_0004);
    reg_write(2, 32'h63);
    reg_read(2, v); chk(v == 32'h60, "R9 low bits zero", v, 32'h60);
    reg_write(0, 32'h1);
    snk_run(4, got);
    settle();
    reg_read(1, v); chk(v == 32'h4 && got == 4, "R4 exact to drive", v, 4);
    reg_write(1, 32'h4);
    put_desc(96, 32'h104, 32'h8000_0002);
    reg_write(0, 32'h1);
    snk_run(2, got);
    settle();
    chk(got == 2 && rx[0] == 8'hC4 && rx[1] == 8'hC5, "R3 reload from base",
        {rx[0], rx[1]}, 16'hC4C5);
    reg_write(1, 32'h4);
  endtask

  task automatic t_zero_size();
    logic [31:0] v; int sent; bit ok = 1;
    fill_data();
    put_desc(128, 32'h100, 32'h8000_0000);
    reg_write(2, 32'h80);
    reg_write(0, 32'h9);
    src_run(256, 8'h01, 1, sent);
    settle();
    chk(sent == 256, "R2 zero size is full region", sent, 256);
    for (int i = 0; i < 256; i++) if (mem_b[256 + i] !== 8'(8'h01 + i * 3)) ok = 0;
    chk(ok && mem_b[512] == 8'hEE, "R2 full region contents", ok, 1);
    reg_read(1, v); chk(v == 32'h4, "R4 exact after full region", v, 4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem_b[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact_to_mem();
    t_short_to_dev();
    t_long_to_mem();
    t_abort_mid();
    t_reload();
    t_zero_size();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule